// File: doc/BRIEF.md
# Masked Multi-Lane Vector Integer ALU

This block runs one element-wise integer add or subtract over a whole vector register. The register file is divided into parallel lanes. Element `i` of every register lives in lane `i mod LANES`, at row `i / LANES`. Each lane owns its slice of storage and a short pipelined adder, and no data moves between lanes. After a start, one group of `LANES` elements enters the lanes on each clock. There are two operation forms. The vector-vector form combines matching elements of two registers. The vector-scalar form adds or subtracts one scalar value at every element position.

The command also carries an active length and a 64-bit mask with an enable. Only elements below the active length are written. When the mask is enabled, only elements whose mask bit is 1 are written. A masked-off element still uses its slot in the lane pipeline. Its result is discarded at write-back, and it can never raise the signed-overflow flag. The run time therefore depends only on the length. An element read port and an element write port give access to the storage when the block is idle. The write port is used to preload operands.

Top module: `vmask_alu`

## Requirements
- R1: With `op[1]=0` (vector-vector), element i of `vd` becomes `vs1[i] + vs2[i]` when `op[0]=0`, and `vs1[i] - vs2[i]` when `op[0]=1`, modulo 2^W.
- R2: With `op[1]=1` (vector-scalar), element i of `vd` becomes `vs1[i] + scalar` when `op[0]=0`, and `vs1[i] - scalar` when `op[0]=1`. `vs2` is not used.
- R3: Only elements 0 to VL-1 are written; elements at or above VL keep their value. A `vl` input above 64 acts as 64.
- R4: With `mask_en=1`, element i is written only if bit i of `vm` is 1; every other element keeps its old value.
- R5: With `mask_en=0`, the contents of `vm` are ignored and every element below VL is written.
- R6: For VL>0, `busy` is high for exactly LAT + ceil(VL/LANES) cycles after the start edge. `done` is a one-cycle pulse in the first cycle that `busy` is low again.
- R7: A start with VL=0 never raises `busy`, pulses `done` in the next cycle and writes no element.
- R8: While `done` is high, `ovf` is 1 exactly when some written element overflowed as a signed W-bit value. Elements that are masked off or at/above VL never set it. It holds until the next start.
- R9: While `busy` is high, a new `start` and the element write port are both ignored.
- R10: After reset, all elements read 0 and `busy`, `done` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 2 | bit0: subtract, bit1: scalar form |
| vd | input | 3 | Destination register |
| vs1 | input | 3 | First source register |
| vs2 | input | 3 | Second source register (vector-vector form) |
| scalar | input | 16 | Scalar operand (vector-scalar form) |
| vl | input | 7 | Active length; values above 64 act as 64 |
| vm | input | 64 | Per-element mask, bit i for element i |
| mask_en | input | 1 | Apply `vm` when 1 |
| wr_en | input | 1 | Element write strobe (idle only) |
| wr_reg | input | 3 | Register of the element write |
| wr_idx | input | 6 | Element index of the write |
| wr_data | input | 16 | Element write data |
| rd_reg | input | 3 | Register of the element read |
| rd_idx | input | 6 | Element index of the read |
| rd_data | output | 16 | Combinational element read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Signed overflow in a written element of the last operation |

## Verification
Full-length add and subtract runs with dense operand patterns check the arithmetic in every lane and at every row. A run with a length that does not fill its last group, and a run with an oversized length, separate correct length limiting from an off-by-one group count. Interleaved mask patterns with the mask enabled and disabled show whether write-back is gated per element or per group. They also show that the enable, and not the mask bits, selects the behaviour. Overflowing values are placed at positions that are masked off, beyond the length, and active. This shows that the flag comes only from results that are written.

// File: rtl/vmau_pkg.sv
package vmau_pkg;

    typedef enum logic [1:0] {
        OP_ADD_VV = 2'd0,
        OP_SUB_VV = 2'd1,
        OP_ADD_VS = 2'd2,
        OP_SUB_VS = 2'd3
    } vop_e;

    function automatic logic op_is_sub(input logic [1:0] op);
        return op[0];
    endfunction

    function automatic logic op_is_scalar(input logic [1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/vmau_lane.sv
module vmau_lane #(
    parameter  int W     = 16,
    parameter  int NREG  = 8,
    parameter  int ROWS  = 16,
    parameter  int LAT   = 2,
    localparam int RW    = $clog2(NREG),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_vld,
    input  logic             iss_act,
    input  logic [ROW_W-1:0] iss_row,
    input  logic [RW-1:0]    src_a,
    input  logic [RW-1:0]    src_b,
    input  logic [RW-1:0]    dst,
    input  logic             sub,
    input  logic             use_scl,
    input  logic [W-1:0]     scl,
    input  logic             wr_en,
    input  logic [RW-1:0]    wr_reg,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [W-1:0]     wr_dat,
    input  logic [RW-1:0]    rd_reg,
    input  logic [ROW_W-1:0] rd_row,
    output logic [W-1:0]     rd_dat,
    output logic             wb_en,
    output logic             wb_ovf
);

    localparam int AW    = RW + ROW_W;
    localparam int DEPTH = NREG * ROWS;

    typedef struct packed {
        logic          vld;
        logic          act;
        logic [AW-1:0] addr;
        logic [W-1:0]  res;
        logic          ovf;
    } stage_t;

    stage_t       pipe_d [LAT];
    stage_t       pipe_q [LAT];
    logic [W-1:0] mem_d  [DEPTH];
    logic [W-1:0] mem_q  [DEPTH];

    logic [W-1:0] opa, opb, sum;
    logic         aovf;

    always_comb begin
        opa = mem_q[{src_a, iss_row}];
        opb = use_scl ? scl : mem_q[{src_b, iss_row}];
        sum = sub ? (opa - opb) : (opa + opb);
        if (sub) aovf = (opa[W-1] != opb[W-1]) && (sum[W-1] != opa[W-1]);
        else     aovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);

        pipe_d[0].vld  = iss_vld;
        pipe_d[0].act  = iss_act;
        pipe_d[0].addr = {dst, iss_row};
        pipe_d[0].res  = sum;
        pipe_d[0].ovf  = aovf;
        for (int k = 1; k < LAT; k++) pipe_d[k] = pipe_q[k-1];

        mem_d  = mem_q;
        wb_en  = pipe_q[LAT-1].vld && pipe_q[LAT-1].act;
        wb_ovf = wb_en && pipe_q[LAT-1].ovf;
        if (wb_en)      mem_d[pipe_q[LAT-1].addr] = pipe_q[LAT-1].res;
        else if (wr_en) mem_d[{wr_reg, wr_row}]   = wr_dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++)   pipe_q[k] <= '0;
            for (int k = 0; k < DEPTH; k++) mem_q[k]  <= '0;
        end else begin
            pipe_q <= pipe_d;
            mem_q  <= mem_d;
        end
    end

    assign rd_dat = mem_q[{rd_reg, rd_row}];

endmodule

// File: rtl/vmau_ctrl.sv
module vmau_ctrl #(
    parameter  int W     = 16,
    parameter  int NREG  = 8,
    parameter  int MVL   = 64,
    parameter  int LANES = 4,
    parameter  int LAT   = 2,
    localparam int RW    = $clog2(NREG),
    localparam int VLW   = $clog2(MVL + 1),
    localparam int ROWS  = MVL / LANES,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [RW-1:0]    vd,
    input  logic [RW-1:0]    vs1,
    input  logic [RW-1:0]    vs2,
    input  logic [W-1:0]     scalar,
    input  logic [VLW-1:0]   vl,
    input  logic [MVL-1:0]   vm,
    input  logic             mask_en,
    input  logic [LANES-1:0] lane_ovf,
    output logic             iss_vld,
    output logic [ROW_W-1:0] iss_row,
    output logic [LANES-1:0] iss_act,
    output logic             sub,
    output logic             use_scl,
    output logic [W-1:0]     scl,
    output logic [RW-1:0]    vd_o,
    output logic [RW-1:0]    vs1_o,
    output logic [RW-1:0]    vs2_o,
    output logic             busy,
    output logic             done,
    output logic             ovf
);
    import vmau_pkg::*;

    localparam int LW = $clog2(LANES);
    localparam int IW = $clog2(MVL);
    localparam int GW = $clog2(ROWS + 1);
    localparam int CW = $clog2(ROWS + LAT + 1);

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [GW-1:0]  grp;
        logic [GW-1:0]  ngrp;
        logic           done;
        logic           ovf;
        logic           sub;
        logic           scl_sel;
        logic [RW-1:0]  vd;
        logic [RW-1:0]  vs1;
        logic [RW-1:0]  vs2;
        logic [W-1:0]   scl;
        logic [VLW-1:0] vl;
        logic [MVL-1:0] vm;
        logic           men;
    } ctl_t;

    ctl_t           s_d, s_q;
    logic           busy_c;
    logic [VLW-1:0] vl_c;
    logic [VLW:0]   ng_w;
    logic [IW-1:0]  e;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        busy_c   = (s_q.cnt != '0);
        iss_vld  = busy_c && (s_q.grp < s_q.ngrp);
        vl_c     = (vl > VLW'(MVL)) ? VLW'(MVL) : vl;
        ng_w     = {1'b0, vl_c} + (VLW+1)'(LANES - 1);

        if (iss_vld) s_d.grp = s_q.grp + GW'(1);
        if (busy_c) begin
            s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.cnt == CW'(1)) s_d.done = 1'b1;
        end
        if (|lane_ovf) s_d.ovf = 1'b1;

        if (start && !busy_c) begin
            s_d.sub     = op_is_sub(op);
            s_d.scl_sel = op_is_scalar(op);
            s_d.vd      = vd;
            s_d.vs1     = vs1;
            s_d.vs2     = vs2;
            s_d.scl     = scalar;
            s_d.vl      = vl_c;
            s_d.vm      = vm;
            s_d.men     = mask_en;
            s_d.grp     = '0;
            s_d.ovf     = 1'b0;
            s_d.ngrp    = GW'(ng_w >> LW);
            if (vl_c == '0) begin
                s_d.cnt  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt  = CW'(s_d.ngrp) + CW'(LAT);
            end
        end

        for (int l = 0; l < LANES; l++) begin
            e          = {s_q.grp[ROW_W-1:0], LW'(l)};
            iss_act[l] = (VLW'(e) < s_q.vl) && (!s_q.men || s_q.vm[e]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign iss_row = s_q.grp[ROW_W-1:0];
    assign sub     = s_q.sub;
    assign use_scl = s_q.scl_sel;
    assign scl     = s_q.scl;
    assign vd_o    = s_q.vd;
    assign vs1_o   = s_q.vs1;
    assign vs2_o   = s_q.vs2;
    assign busy    = busy_c;
    assign done    = s_q.done;
    assign ovf     = s_q.ovf;

endmodule

// File: rtl/vmask_alu.sv
module vmask_alu #(
    parameter  int W     = 16,
    parameter  int NREG  = 8,
    parameter  int MVL   = 64,
    parameter  int LANES = 4,
    parameter  int LAT   = 2,
    localparam int RW    = $clog2(NREG),
    localparam int VLW   = $clog2(MVL + 1),
    localparam int IW    = $clog2(MVL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic [RW-1:0]  vd,
    input  logic [RW-1:0]  vs1,
    input  logic [RW-1:0]  vs2,
    input  logic [W-1:0]   scalar,
    input  logic [VLW-1:0] vl,
    input  logic [MVL-1:0] vm,
    input  logic           mask_en,
    input  logic           wr_en,
    input  logic [RW-1:0]  wr_reg,
    input  logic [IW-1:0]  wr_idx,
    input  logic [W-1:0]   wr_data,
    input  logic [RW-1:0]  rd_reg,
    input  logic [IW-1:0]  rd_idx,
    output logic [W-1:0]   rd_data,
    output logic           busy,
    output logic           done,
    output logic           ovf
);

    localparam int ROWS  = MVL / LANES;
    localparam int ROW_W = $clog2(ROWS);
    localparam int LW    = $clog2(LANES);

    logic             iss_vld;
    logic [ROW_W-1:0] iss_row;
    logic [LANES-1:0] iss_act;
    logic             sub, use_scl;
    logic [W-1:0]     scl;
    logic [RW-1:0]    vd_q, vs1_q, vs2_q;
    logic [LANES-1:0] lane_wb, lane_ovf;
    logic [W-1:0]     lane_rd [LANES];

    vmau_ctrl #(
        .W(W), .NREG(NREG), .MVL(MVL), .LANES(LANES), .LAT(LAT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .vd(vd), .vs1(vs1), .vs2(vs2), .scalar(scalar), .vl(vl),
        .vm(vm), .mask_en(mask_en), .lane_ovf(lane_ovf),
        .iss_vld(iss_vld), .iss_row(iss_row), .iss_act(iss_act),
        .sub(sub), .use_scl(use_scl), .scl(scl),
        .vd_o(vd_q), .vs1_o(vs1_q), .vs2_o(vs2_q),
        .busy(busy), .done(done), .ovf(ovf)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic lwr;
        assign lwr = wr_en && !busy && (wr_idx[LW-1:0] == LW'(l));

        vmau_lane #(
            .W(W), .NREG(NREG), .ROWS(ROWS), .LAT(LAT)
        ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .iss_vld(iss_vld), .iss_act(iss_act[l]), .iss_row(iss_row),
            .src_a(vs1_q), .src_b(vs2_q), .dst(vd_q),
            .sub(sub), .use_scl(use_scl), .scl(scl),
            .wr_en(lwr), .wr_reg(wr_reg), .wr_row(wr_idx[IW-1:LW]),
            .wr_dat(wr_data),
            .rd_reg(rd_reg), .rd_row(rd_idx[IW-1:LW]), .rd_dat(lane_rd[l]),
            .wb_en(lane_wb[l]), .wb_ovf(lane_ovf[l])
        );
    end

    assign rd_data = lane_rd[rd_idx[LW-1:0]];

endmodule

// File: rtl/vmask_alu_chk.sv
module vmask_alu_chk #(
    parameter  int MVL   = 64,
    parameter  int LANES = 4,
    parameter  int LAT   = 2,
    localparam int VLW   = $clog2(MVL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VLW-1:0]   vl,
    input logic             busy,
    input logic             done,
    input logic             ovf,
    input logic             iss_vld,
    input logic [LANES-1:0] lane_wb,
    input logic [LANES-1:0] lane_ovf
);

    int vlc, exp_c, run_q, exp_q;

    always_comb begin
        vlc   = (int'(vl) > MVL) ? MVL : int'(vl);
        exp_c = (vlc == 0) ? 0 : (vlc + LANES - 1) / LANES + LAT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
            exp_q <= 0;
        end else if (start && !busy) begin
            run_q <= 0;
            exp_q <= exp_c;
        end else if (busy) begin
            run_q <= run_q + 1;
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_fall_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == exp_q));

    p_wb_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_wb) |-> busy);

    p_issue_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> busy);

    p_vl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (vl == '0)) |=> (!busy && done));

    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(start && !busy) && !(|lane_ovf)) |=> $stable(ovf));

    p_ovf_from_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_ovf & ~lane_wb) == '0));

endmodule

bind vmask_alu vmask_alu_chk #(.MVL(MVL), .LANES(LANES), .LAT(LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .busy(busy),
    .done(done), .ovf(ovf), .iss_vld(iss_vld), .lane_wb(lane_wb),
    .lane_ovf(lane_ovf)
);

// File: tb/vmask_alu_tb_top.sv
module vmask_alu_tb_top;
    localparam int W = 16, NREG = 8, MVL = 64, LANES = 4, LAT = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, start, mask_en, wr_en, busy, done, ovf;
    logic [1:0] op;
    logic [2:0] vd, vs1, vs2, wr_reg, rd_reg;
    logic [W-1:0] scalar, wr_data, rd_data;
    logic [6:0] vl;
    logic [MVL-1:0] vm;
    logic [5:0] wr_idx, rd_idx;

    vmask_alu dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd),
        .vs1(vs1), .vs2(vs2), .scalar(scalar), .vl(vl), .vm(vm),
        .mask_en(mask_en), .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_reg(rd_reg), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .done(done), .ovf(ovf)
    );

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] mdl [NREG][MVL];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int r, input int i, output logic [W-1:0] v);
        rd_reg = 3'(r);
        rd_idx = 6'(i);
        #1 v = rd_data;
    endtask

    task automatic cmp_reg(input int r, input string req);
        logic [W-1:0] v;
        for (int i = 0; i < MVL; i++) begin
            rd(r, i, v);
            chk(v === mdl[r][i], req, v, mdl[r][i]);
        end
    endtask

    task automatic wr_elem(input int r, input int i, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 3'(r); wr_idx = 6'(i); wr_data = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
        mdl[r][i] = v;
    endtask

    task automatic apply_model(input logic [1:0] o, input int d, input int s1, input int s2,
                               input logic [W-1:0] sc, input int l, input logic [MVL-1:0] m,
                               input bit me, output bit ov);
        int vle;
        ov  = 1'b0;
        vle = (l > MVL) ? MVL : l;
        for (int i = 0; i < vle; i++) begin
            logic [W-1:0] a, b;
            int s;
            a = mdl[s1][i];
            b = o[1] ? sc : mdl[s2][i];
            s = o[0] ? (int'($signed(a)) - int'($signed(b))) : (int'($signed(a)) + int'($signed(b)));
            if (!me || m[i]) begin
                if (s > 32767 || s < -32768) ov = 1'b1;
                mdl[d][i] = o[0] ? (a - b) : (a + b);
            end
        end
    endtask

    task automatic run_op(input logic [1:0] o, input int d, input int s1, input int s2,
                          input logic [W-1:0] sc, input int l, input logic [MVL-1:0] m,
                          input bit me);
        int cyc, vle, exp_cyc;
        bit exp_ov;
        @(negedge clk);
        op = o; vd = 3'(d); vs1 = 3'(s1); vs2 = 3'(s2); scalar = sc;
        vl = 7'(l); vm = m; mask_en = me; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
        apply_model(o, d, s1, s2, sc, l, m, me, exp_ov);
        vle     = (l > MVL) ? MVL : l;
        exp_cyc = (vle == 0) ? 0 : (vle + LANES - 1) / LANES + LAT;
        chk(cyc == exp_cyc, (vle == 0) ? "R7" : "R6", cyc, exp_cyc);
        chk(done === 1'b1, (vle == 0) ? "R7" : "R6", done, 1);
        chk(ovf === exp_ov, "R8", ovf, exp_ov);
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        chk(busy === 1'b0, "R10", busy, 0);
        chk(done === 1'b0, "R10", done, 0);
        chk(ovf === 1'b0, "R10", ovf, 0);
        cmp_reg(0, "R10");
        rd(7, 63, v);
        chk(v === '0, "R10", v, 0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < MVL; i++) begin
            wr_elem(1, i, 16'(i * 37 + 5));
            wr_elem(2, i, 16'((i * 1013) ^ 16'h5a5a));
        end
        cmp_reg(1, "R10");
    endtask

    task automatic t_vv;
        run_op(2'd0, 3, 1, 2, 16'h0, 64, '0, 1'b0);
        cmp_reg(3, "R1");
        run_op(2'd1, 4, 1, 2, 16'h0, 37, '0, 1'b0);
        cmp_reg(4, "R1 R3");
    endtask

    task automatic t_vs;
        run_op(2'd2, 5, 1, 6, 16'h1234, 64, '0, 1'b0);
        cmp_reg(5, "R2");
        run_op(2'd3, 5, 5, 1, 16'd7, 21, '0, 1'b0);
        cmp_reg(5, "R2 R3");
    endtask

    task automatic t_vl_over;
        run_op(2'd0, 6, 2, 2, 16'h0, 100, '0, 1'b0);
        cmp_reg(6, "R3");
    endtask

    task automatic t_mask;
        run_op(2'd1, 3, 2, 1, 16'h0, 50, 64'hAAAA_5555_F0F0_0F0F, 1'b1);
        cmp_reg(3, "R4");
        run_op(2'd2, 4, 1, 0, 16'd1, 64, '0, 1'b0);
        cmp_reg(4, "R5");
    endtask

    task automatic t_vl0;
        run_op(2'd0, 3, 1, 2, 16'h0, 0, '1, 1'b0);
        cmp_reg(3, "R7");
    endtask

    task automatic t_ovf;
        wr_elem(7, 3, 16'h7FFF);
        wr_elem(7, 10, 16'h8000);
        run_op(2'd2, 6, 7, 0, 16'd1, 64, ~(64'd1 << 3), 1'b1);
        cmp_reg(6, "R8");
        run_op(2'd2, 6, 7, 0, 16'd1, 3, '0, 1'b0);
        cmp_reg(6, "R8");
        run_op(2'd3, 6, 7, 0, 16'd1, 64, '0, 1'b0);
        cmp_reg(6, "R8");
        repeat (5) @(negedge clk);
        chk(ovf === 1'b1, "R8", ovf, 1);
    endtask

    task automatic t_busy_ignore;
        bit ov;
        @(negedge clk);
        op = 2'd0; vd = 3'd0; vs1 = 3'd1; vs2 = 3'd2; vl = 7'd64;
        mask_en = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op = 2'd3; vd = 3'd7; vs1 = 3'd1; scalar = 16'd9;
        wr_en = 1'b1; wr_reg = 3'd7; wr_idx = 6'd5; wr_data = 16'hBEEF;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        while (busy) @(negedge clk);
        apply_model(2'd0, 0, 1, 2, 16'h0, 64, '0, 1'b0, ov);
        cmp_reg(0, "R9");
        cmp_reg(7, "R9");
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; op = '0; vd = '0; vs1 = '0;
        vs2 = '0; scalar = '0; vl = '0; vm = '0; mask_en = 1'b0;
        wr_reg = '0; wr_idx = '0; wr_data = '0; rd_reg = '0; rd_idx = '0;
        for (int r = 0; r < NREG; r++)
            for (int i = 0; i < MVL; i++) mdl[r][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fill;
        t_vv;
        t_vs;
        t_vl_over;
        t_mask;
        t_vl0;
        t_ovf;
        t_busy_ignore;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL R6: watchdog expired, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule